// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped general-purpose I/O controller for up to eight groups of 32 pins. The default setting has 144 pins, so there are five groups. Software reaches it through a plain 32-bit register bus. The bus has a byte address, a write enable, write data and a read-data return. Each group of 32 pins holds five words:

- a direction word;
- an output latch that can be written directly;
- a port that sets latch bits where the written bit is one;
- a port that clears latch bits where the written bit is one;
- an input view that passes the pad levels through a two-stage synchronizer.

The pads appear as three separate vectors: output level, output enable and input level. The bench loops the driven levels back onto the input vector, so the input view also reflects pins that are configured as outputs. Interrupt edge logic lives elsewhere. It shares this address map, and the words it owns read as zero here.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every valid direction bit is 1 and every output latch bit is 0, so `padOe` and `padOut` are all zero.
- R2: A direction bit of 1 makes the pin an input (`padOe` low), and a 0 makes it a driven output (`padOe` high) from the cycle after the write.
- R3: Writing the set port ORs the written ones into the output latch, and bits written as 0 keep their value.
- R4: Writing the clear port clears the latch bits written as 1, and bits written as 0 keep their value.
- R5: The output latch word can be written directly and reads back its current value. `padOut` follows the latch whatever the direction.
- R6: The input word returns the pad level two clock edges after it was sampled, whether the pin is an input or an output.
- R7: Pin bits at or above `PIN_COUNT` read as zero in every word and ignore writes.
- R8: Group g starts at byte offset 0x10 + g*0x28. Its words are direction at +0x00, output latch at +0x04, set port at +0x08, clear port at +0x0C and input at +0x10. The set and clear ports read as zero.
- R9: An address that is not word-aligned, below 0x10, in the range +0x14 to +0x24 of a group, or beyond the last group reads as zero, and a write to it changes nothing.
- R10: Read data is combinational and belongs to the address presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe for this cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| padIn | input | PIN_COUNT | Pad input levels |
| padOut | output | PIN_COUNT | Pad output levels (latch) |
| padOe | output | PIN_COUNT | Pad output enables |

## Verification
Two functions can meet in one cycle: a write that changes an output latch, and a read of the input word for that same pin. The pad loops back, so the read must still show the level from two edges earlier. The bench provokes this by setting a looped-back output bit and reading the input word in the very next cycles. A behavioural model keeps a history queue of pad samples and judges each read against that history, not against the latch. A long random phase mixes latch writes, external pad changes and input reads to every group.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  // widest group index supported (up to 8 groups of 32 pins)
  localparam int GRP_IDX_W = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_OUT,
    SEL_SET,
    SEL_CLR,
    SEL_IN
  } wordSel_e;

  // strobes handed from the address decode to the register datapath
  typedef struct packed {
    logic [GRP_IDX_W-1:0] group;
    wordSel_e             sel;
    logic                 wr;
  } busStrobe_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NUM_GROUPS   = 5,
  parameter int GROUP_BASE   = 16,
  parameter int GROUP_STRIDE = 40
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobe_t        strobe
);

  localparam int WORDS_MAPPED = 5;
  localparam int SPAN_BYTES   = WORDS_MAPPED * 4;

  always_comb begin
    logic [31:0] addrExt;
    logic [31:0] start;
    logic [31:0] off;
    strobe  = '{group: '0, sel: SEL_NONE, wr: 1'b0};
    addrExt = 32'(busAddr);
    for (int g = 0; g < NUM_GROUPS; g++) begin
      start = 32'(GROUP_BASE + g * GROUP_STRIDE);
      off   = addrExt - start;
      if (addrExt[1:0] == 2'b00 && addrExt >= start && off < 32'(SPAN_BYTES)) begin
        strobe.group = GRP_IDX_W'(g);
        case (off[4:2])
          3'd0:    strobe.sel = SEL_DIR;
          3'd1:    strobe.sel = SEL_OUT;
          3'd2:    strobe.sel = SEL_SET;
          3'd3:    strobe.sel = SEL_CLR;
          3'd4:    strobe.sel = SEL_IN;
          default: strobe.sel = SEL_NONE;
        endcase
      end
    end
    strobe.wr = busWrEn && (strobe.sel != SEL_NONE);
  end

endmodule

// File: rtl/gpio_pin_datapath.sv
module gpio_pin_datapath
  import gpio_ctrl_pkg::*;
#(
  parameter int PIN_COUNT  = 144,
  parameter int NUM_GROUPS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [31:0]          wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [31:0]          rdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  localparam int NPINS = NUM_GROUPS * 32;

  function automatic logic [31:0] groupMask(int g);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (g * 32 + b) < PIN_COUNT;
    return m;
  endfunction

  logic [NPINS-1:0] padWide;
  logic [NPINS-1:0] dirAll;
  logic [NPINS-1:0] outAll;
  logic [NPINS-1:0] inAll;

  always_comb begin
    padWide                = '0;
    padWide[PIN_COUNT-1:0] = padIn;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    localparam logic [31:0] VALID = groupMask(g);
    logic [31:0] dirQ, outQ, syncA, syncB;
    logic        hit;

    assign hit = strobe.wr && (strobe.group == GRP_IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ <= VALID;
        outQ <= '0;
      end else if (hit) begin
        case (strobe.sel)
          SEL_DIR: dirQ <= wrData & VALID;
          SEL_OUT: outQ <= wrData & VALID;
          SEL_SET: outQ <= outQ | (wrData & VALID);
          SEL_CLR: outQ <= outQ & ~wrData;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= '0;
        syncB <= '0;
      end else begin
        syncA <= padWide[g*32 +: 32];
        syncB <= syncA;
      end
    end

    assign dirAll[g*32 +: 32] = dirQ;
    assign outAll[g*32 +: 32] = outQ;
    assign inAll[g*32 +: 32]  = syncB;
  end

  always_comb begin
    rdData = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (strobe.group == GRP_IDX_W'(g)) begin
        case (strobe.sel)
          SEL_DIR: rdData = dirAll[g*32 +: 32];
          SEL_OUT: rdData = outAll[g*32 +: 32];
          SEL_IN:  rdData = inAll[g*32 +: 32];
          default: rdData = '0;
        endcase
      end
    end
  end

  assign padOe  = ~dirAll[PIN_COUNT-1:0];
  assign padOut = outAll[PIN_COUNT-1:0];

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int PIN_COUNT    = 144,
  parameter int ADDR_W       = 8,
  parameter int GROUP_BASE   = 16,
  parameter int GROUP_STRIDE = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  localparam int NUM_GROUPS = (PIN_COUNT + 31) / 32;

  busStrobe_t strobe;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS),
    .GROUP_BASE(GROUP_BASE), .GROUP_STRIDE(GROUP_STRIDE)
  ) i_decode (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  gpio_pin_datapath #(
    .PIN_COUNT(PIN_COUNT), .NUM_GROUPS(NUM_GROUPS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .padIn(padIn), .rdData(busRdData), .padOut(padOut), .padOe(padOe)
  );

endmodule

// File: rtl/gpio_bank_ctrl_sva.sv
module gpio_bank_ctrl_sva #(
  parameter int PIN_COUNT    = 144,
  parameter int ADDR_W       = 8,
  parameter int GROUP_BASE   = 16,
  parameter int GROUP_STRIDE = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic [31:0]       padIn,
  input logic [31:0]       padOut,
  input logic [31:0]       padOe
);

  localparam int NUM_GROUPS = (PIN_COUNT + 31) / 32;
  localparam int LAST_G     = NUM_GROUPS - 1;
  localparam int LAST_VALID = PIN_COUNT - LAST_G * 32;
  localparam logic [63:0] LAST_ONES = (64'd1 << LAST_VALID) - 64'd1;
  localparam logic [31:0] LAST_BAD  = ~LAST_ONES[31:0];
  localparam logic [ADDR_W-1:0] DIR0     = ADDR_W'(GROUP_BASE);
  localparam logic [ADDR_W-1:0] SET0     = ADDR_W'(GROUP_BASE + 8);
  localparam logic [ADDR_W-1:0] CLR0     = ADDR_W'(GROUP_BASE + 12);
  localparam logic [ADDR_W-1:0] IN0      = ADDR_W'(GROUP_BASE + 16);
  localparam logic [ADDR_W-1:0] LAST_OUT = ADDR_W'(GROUP_BASE + LAST_G * GROUP_STRIDE + 4);

  logic [1:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0));

  assert_dir_drives_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DIR0) |=> (padOe == ~$past(busWrData)));

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == SET0) |=> ((padOut & $past(busWrData)) == $past(busWrData)));

  assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CLR0) |=> ((padOut & $past(busWrData)) == '0));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(padOut));

  assert_input_delay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && busAddr == IN0) |-> (busRdData == $past(padIn, 2)));

  assert_high_pins_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == LAST_OUT) |-> ((busRdData & LAST_BAD) == '0));

  assert_misaligned_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> (busRdData == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_sva #(
  .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W),
  .GROUP_BASE(GROUP_BASE), .GROUP_STRIDE(GROUP_STRIDE)
) i_sva (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData),
  .padIn(padIn[31:0]), .padOut(padOut[31:0]), .padOe(padOe[31:0])
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;

  localparam int PC = 144;
  localparam int NG = 5;
  localparam int NP = NG * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [PC-1:0] padIn, padOut, padOe, extPad;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mDir [NG];
  logic [31:0] mOut [NG];
  logic [NP-1:0] padHist [$];

  always #2 clk = ~clk;

  assign padIn = (padOut & padOe) | (extPad & ~padOe);

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [31:0] gmask(int g);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (g * 32 + b) < PC;
    return m;
  endfunction

  // returns word offset inside group, or -1 when unmapped; g gets the group
  function automatic int locate(logic [7:0] a, output int g);
    int ai = int'(a);
    g = 0;
    if (a[1:0] != 2'b00 || ai < 16) return -1;
    g = (ai - 16) / 40;
    if (g >= NG) return -1;
    if (((ai - 16) % 40) > 16) return -1;
    return (ai - 16) % 40;
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    int g;
    int w = locate(a, g);
    logic [NP-1:0] inVal = (padHist.size() >= 2) ? padHist[$-1] : '0;
    case (w)
      0:  return mDir[g];
      4:  return mOut[g];
      16: return inVal[g*32 +: 32];
      default: return '0;
    endcase
  endfunction

  function automatic string readTag(logic [7:0] a);
    int g;
    int w = locate(a, g);
    string t;
    case (w)
      0:  t = "R2 R8";
      4:  t = "R5 R8";
      8, 12: t = "R3 R4 R8";
      16: t = "R6 R8";
      default: t = "R9";
    endcase
    if (w >= 0 && g == NG - 1) t = {t, " R7"};
    return {t, " R10"};
  endfunction

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic [7:0] a, logic we, logic [31:0] d);
    logic [NP-1:0] sample, expOe, expOut;
    int g;
    int w;
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = d;
    #1;
    for (int k = 0; k < NG; k++) begin
      expOe[k*32 +: 32]  = ~mDir[k] & gmask(k);
      expOut[k*32 +: 32] = mOut[k];
    end
    check(readTag(a), NP'(busRdData), NP'(expRead(a)));
    check("R2", NP'(padOe), expOe);
    check("R3 R4 R5", NP'(padOut), expOut);
    sample = NP'(padIn);
    @(posedge clk);
    #1;
    padHist.push_back(sample);
    w = locate(a, g);
    if (we) begin
      case (w)
        0:  mDir[g] = d & gmask(g);
        4:  mOut[g] = d & gmask(g);
        8:  mOut[g] = mOut[g] | (d & gmask(g));
        12: mOut[g] = mOut[g] & ~d;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] unm [8] = '{8'h00, 8'h0C, 8'h24, 8'h34, 8'h11, 8'h15, 8'hD8, 8'hFC};
    extPad = '0;
    for (int g = 0; g < NG; g++) begin
      mDir[g] = gmask(g);
      mOut[g] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    busAddr = 8'h10; #1;
    check("R1", NP'(busRdData), NP'(32'hFFFF_FFFF));
    check("R1", NP'(padOe), '0);
    check("R1", NP'(padOut), '0);
    busAddr = 8'hB0; #1;
    check("R1 R7", NP'(busRdData), NP'(32'h0000_FFFF));
    rstN = 1'b1;

    // direction and direct latch writes
    cycle(8'h10, 1, 32'h0000_FFFF);
    cycle(8'h14, 1, 32'hA5A5_A5A5);
    cycle(8'h14, 0, 0);
    cycle(8'h18, 1, 32'h0F0F_0000);
    cycle(8'h14, 0, 0);
    cycle(8'h1C, 1, 32'h00FF_00FF);
    cycle(8'h14, 0, 0);
    cycle(8'h18, 1, 32'h0);
    cycle(8'h1C, 1, 32'h0);
    cycle(8'h18, 0, 0);
    // loopback: set an output pin and read the input word right after
    cycle(8'h1C, 1, 32'h8000_0000);
    cycle(8'h20, 0, 0);
    cycle(8'h18, 1, 32'h8000_0000);
    cycle(8'h20, 0, 0);
    cycle(8'h20, 0, 0);
    cycle(8'h20, 0, 0);
    // external pad patterns on inputs
    extPad = {PC/16{16'h3C5A}};
    cycle(8'h48, 0, 0);
    cycle(8'h48, 0, 0);
    cycle(8'h48, 0, 0);
    cycle(8'h20, 0, 0);
    extPad = ~extPad;
    cycle(8'hC0, 0, 0);
    cycle(8'hC0, 0, 0);
    cycle(8'hC0, 0, 0);
    // last group: upper pins absent
    cycle(8'hB0, 1, 32'h0);
    cycle(8'hB4, 1, 32'hFFFF_FFFF);
    cycle(8'hB4, 0, 0);
    cycle(8'hB8, 1, 32'hFFFF_FFFF);
    cycle(8'hB0, 0, 0);
    cycle(8'hC0, 0, 0);
    // unmapped writes and reads
    for (int i = 0; i < 8; i++) cycle(unm[i], 1, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) cycle(unm[i], 0, 0);
    for (int g = 0; g < NG; g++) begin
      cycle(8'(16 + g * 40), 0, 0);
      cycle(8'(20 + g * 40), 0, 0);
    end
    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 9);
      if (sel < 8) a = 8'(16 + $urandom_range(0, NG - 1) * 40 + $urandom_range(0, 4) * 4);
      else a = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) extPad = {PC/16{16'($urandom)}};
      cycle(a, 1'($urandom_range(0, 1)), $urandom);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule